// File: doc/BRIEF.md
# Reset-Triggered Boot Streamer for a Serial Flash

This block sits behind the serial port of a flash device and lets a host fetch boot code without sending any command. A 32-bit boot configuration word holds an enable flag, a start block and a wait count. When the flag is set at the moment a reset ends, the first chip-select assertion skips the opcode and address phases. The block waits the configured number of serial clocks, then streams bytes from the start of the chosen 512-byte block for as long as chip-select stays low.

Outside that single session, the port decodes two commands that read or write the configuration word. The word models non-volatile storage: no reset clears it, and it powers up as all zeros. The memory array is reached through a plain combinational byte-read port. The serial pins are sampled with the block clock, which must run several times faster than the serial clock. The serial clock idles low.

Top module: `boot_stream_seq`

## Requirements
- R1: The configuration word is decoded as follows. Bits 31:9 are the start block, so the first byte address is the field times 512. Bits 8:1 are the wait count D. Bit 0 is the enable flag.
- R2: After power-up the configuration reads as 0x00000000 and no boot session occurs.
- R3: The configuration keeps its value across both the hardware reset (`rst_n` low) and the software reset (a one-cycle `sw_rst` pulse).
- R4: If the enable flag is 1 when either reset ends, the next falling edge of `cs_n` starts a boot session with no opcode.
- R5: In a boot session the first data bit is valid at rising serial-clock edge D+1 after `cs_n` falls. `miso` stays 0 at the D rising edges before it.
- R6: Boot data starts at the start-block address and is sent most-significant bit first. The address advances by one per byte while `cs_n` stays low.
- R7: A rising edge on `cs_n` ends the boot session and returns `miso` to 0. Every later selection decodes an opcode until the next reset.
- R8: Opcode 0x14, sent MSB first in the first 8 clocks, returns the 32-bit configuration MSB first on the next 32 clocks.
- R9: Opcode 0x15 followed by 32 bits, MSB first, replaces the configuration when the 32nd bit is captured. Deselecting earlier leaves the configuration unchanged.
- R10: `mosi` is captured on rising serial-clock edges. `miso` changes only after a falling serial-clock edge, a chip-select edge or a software reset.
- R11: The enable flag is sampled only when a reset ends. Writing it later has no effect before the next reset.
- R12: Any other opcode keeps `miso` at 0 for the rest of the selection and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low hardware/power-on reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| mem_addr | output | 32 | Byte address into the memory array |
| mem_data | input | 8 | Byte read combinationally at `mem_addr` |

## Verification
A table of boot sessions varies four things: the start block (zero, small, middle and topmost), the wait count (zero, one, five and twenty) and the session length, and the sessions alternate between hardware and software reset. Together these separate errors in address alignment, off-by-one in the wait count, bit order and byte increment. After each session a configuration read confirms that opcode decoding has resumed. Directed cases cover several situations, each of which would look like a boot if the design were wrong or would lose the stored word:
- the power-up word;
- retention across both resets;
- an enable written after reset;
- a truncated write;
- an unknown opcode.

// File: rtl/boot_stream_seq.sv
module boot_stream_seq #(
  parameter int          CFG_W     = 32,
  parameter int          BLK_LSB   = 9,
  parameter int          DLY_W     = 8,
  parameter logic [7:0]  OP_CFG_RD = 8'h14,
  parameter logic [7:0]  OP_CFG_WR = 8'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             mosi,
  output logic             miso,
  output logic [CFG_W-1:0] mem_addr,
  input  logic [7:0]       mem_data
);

  localparam int CNT_W = $clog2(CFG_W);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_BOOT, S_OPC, S_RDCFG, S_WRCFG, S_SKIP} st_t;

  st_t              st;
  logic             cs_q, sck_q, armed, arm_pend, miso_q;
  logic [DLY_W-1:0] cnt;
  logic [CNT_W-1:0] bcnt;
  logic [CFG_W-1:0] sh, addr_q;
  logic [CFG_W-1:0] cfg_q = '0;

  wire              rise    = sck & ~sck_q & ~cs_n;
  wire              fall    = ~sck & sck_q & ~cs_n;
  wire              cs_fall = cs_q & ~cs_n;
  wire              cs_rise = ~cs_q & cs_n;
  wire [DLY_W-1:0]  dly     = cfg_q[DLY_W:1];
  wire [CFG_W-1:0]  start   = {cfg_q[CFG_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
  wire [7:0]        opc     = {sh[6:0], mosi};

  logic boot_ld;
  always_comb begin
    boot_ld = 1'b0;
    if (!sw_rst && !cs_rise) begin
      case (st)
        S_IDLE:  boot_ld = cs_fall && armed && !arm_pend && (dly == '0);
        S_WAIT:  boot_ld = fall && (cnt == dly);
        S_BOOT:  boot_ld = fall && (bcnt == CNT_W'(7));
        default: boot_ld = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !sw_rst && st == S_WRCFG && rise && bcnt == CNT_W'(CFG_W-1))
      cfg_q <= {sh[CFG_W-2:0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      st       <= S_IDLE;
      armed    <= 1'b0;
      arm_pend <= 1'b1;
      cnt      <= '0;
      bcnt     <= '0;
      sh       <= '0;
      addr_q   <= '0;
      miso_q   <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (sw_rst) begin
        st       <= S_IDLE;
        armed    <= 1'b0;
        arm_pend <= 1'b1;
        miso_q   <= 1'b0;
      end else begin
        if (arm_pend) begin
          armed    <= cfg_q[0];
          arm_pend <= 1'b0;
          addr_q   <= start;
        end
        if (cs_rise) begin
          st     <= S_IDLE;
          miso_q <= 1'b0;
        end else begin
          case (st)
            S_IDLE: if (cs_fall) begin
              bcnt <= '0;
              cnt  <= '0;
              if (armed && !arm_pend) begin
                armed <= 1'b0;
                st    <= S_WAIT;
              end else begin
                st <= S_OPC;
              end
            end
            S_WAIT: if (rise) cnt <= cnt + DLY_W'(1);
            S_BOOT: if (fall) begin
              miso_q <= sh[CFG_W-1];
              sh     <= sh << 1;
              bcnt   <= bcnt + CNT_W'(1);
            end
            S_OPC: if (rise) begin
              sh   <= {sh[CFG_W-2:0], mosi};
              bcnt <= bcnt + CNT_W'(1);
              if (bcnt == CNT_W'(7)) begin
                bcnt <= '0;
                if (opc == OP_CFG_RD) begin
                  st <= S_RDCFG;
                  sh <= cfg_q;
                end else if (opc == OP_CFG_WR) begin
                  st <= S_WRCFG;
                end else begin
                  st <= S_SKIP;
                end
              end
            end
            S_RDCFG: if (fall) begin
              miso_q <= sh[CFG_W-1];
              sh     <= sh << 1;
            end
            S_WRCFG: if (rise) begin
              sh   <= {sh[CFG_W-2:0], mosi};
              bcnt <= bcnt + CNT_W'(1);
              if (bcnt == CNT_W'(CFG_W-1)) st <= S_SKIP;
            end
            default: ;
          endcase
          if (boot_ld) begin
            st     <= S_BOOT;
            miso_q <= mem_data[7];
            sh     <= {mem_data[6:0], {(CFG_W-7){1'b0}}};
            addr_q <= addr_q + CFG_W'(1);
            bcnt   <= '0;
          end
        end
      end
    end
  end

  assign miso     = miso_q;
  assign mem_addr = addr_q;

  assert_miso_low_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_n) |-> !miso_q);

  assert_one_session_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BOOT) |-> !armed);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == S_WRCFG && rise) |=> $stable(cfg_q));

  assert_miso_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> ($past(sck_q && !sck) || $past(cs_q != cs_n) || $past(sw_rst)));

  assert_block_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_BOOT) |-> (mem_addr[BLK_LSB-1:0] == BLK_LSB'(1)));

  assert_swrst_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (st == S_IDLE && arm_pend));

endmodule

// File: tb/boot_stream_seq_bench.sv
`timescale 1ns/1ps
module boot_stream_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[31:24] ^ 8'h3C;
  endfunction

  assign mem_data = mem_byte(mem_addr);

  boot_stream_seq u_boot_stream_seq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // {start block[22:0], wait count[7:0], bytes[2:0]}
  localparam logic [33:0] VEC [4] = '{
    {23'd0,       8'd0,  3'd4},
    {23'd3,       8'd1,  3'd3},
    {23'h7FFFFF,  8'd5,  3'd3},
    {23'd77,      8'd20, 3'd4}
  };

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      rx   = {rx[62:0], miso};
      mosi = tx[n-1-i];
      sck  = 1'b1;
      wclk(4);
      sck  = 1'b0;
      wclk(4);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    wclk(4);
  endtask

  task automatic write_cfg(input logic [31:0] c);
    logic [63:0] r;
    xfer(40, {24'd0, 8'h15, c}, r);
  endtask

  task automatic read_cfg(output logic [31:0] c);
    logic [63:0] r;
    xfer(40, {24'd0, 8'h14, 32'd0}, r);
    c = r[31:0];
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
  endtask

  task automatic soft_reset();
    sw_rst = 1'b1;
    wclk(1);
    sw_rst = 1'b0;
    wclk(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    logic [63:0] r;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);

    chk("R7 miso idle after reset", {63'd0, miso}, 64'd0);
    read_cfg(c);
    chk("R2 power-up config", {32'd0, c}, 64'd0);

    write_cfg({23'd5, 8'd2, 1'b1});
    read_cfg(c);
    chk("R11 enable written after reset gives no boot", {32'd0, c}, {32'd0, 23'd5, 8'd2, 1'b1});

    write_cfg(32'hA5C3_1E40);
    hw_reset();
    read_cfg(c);
    chk("R3 config kept over hardware reset", {32'd0, c}, 64'hA5C3_1E40);
    soft_reset();
    read_cfg(c);
    chk("R3 config kept over software reset", {32'd0, c}, 64'hA5C3_1E40);

    xfer(24, {40'd0, 8'h15, 16'hFFFF}, r);
    read_cfg(c);
    chk("R9 truncated write ignored", {32'd0, c}, 64'hA5C3_1E40);

    xfer(40, {24'd0, 8'h9F, 32'hFFFF_FFFF}, r);
    chk("R12 unknown opcode keeps miso low", r, 64'd0);
    read_cfg(c);
    chk("R12 unknown opcode leaves config", {32'd0, c}, 64'hA5C3_1E40);

    // Boot sessions: checks also cover the R10 capture and launch edges
    for (int k = 0; k < 4; k++) begin
      logic [22:0] blk;
      logic [7:0]  dly;
      int          nb, n;
      logic [63:0] expd, mask;
      blk = VEC[k][33:11];
      dly = VEC[k][10:3];
      nb  = int'(VEC[k][2:0]);
      n   = int'(dly) + nb * 8;
      write_cfg({blk, dly, 1'b1});
      if (k % 2 == 0) hw_reset(); else soft_reset();
      expd = '0;
      for (int b = 0; b < nb; b++)
        expd = {expd[55:0], mem_byte({blk, 9'd0} + 32'(b))};
      mask = (64'd1 << (nb * 8)) - 64'd1;
      xfer(n, 64'd0, r);
      chk($sformatf("R1 R4 R6 boot data vector %0d", k), r & mask, expd);
      chk($sformatf("R5 quiet wait vector %0d", k), r >> (nb * 8), 64'd0);
      read_cfg(c);
      chk($sformatf("R7 R8 opcode decode after session %0d", k), {32'd0, c}, {32'd0, blk, dly, 1'b1});
    end

    write_cfg({23'd9, 8'd0, 1'b0});
    hw_reset();
    read_cfg(c);
    chk("R4 disabled flag gives no boot", {32'd0, c}, {32'd0, 23'd9, 8'd0, 1'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule